// File: doc/BRIEF.md
# Glitch-Free Base Clock Selector

This block produces a single base clock from one of two free-running sources that bear no phase or frequency relation to each other: a reference clock taken from a crystal, and a clock taken from a VCO. Whichever source is chosen is halved in frequency, and the halved clock is driven onto the base clock output. A select input chooses the source. A stop request overrides the select input and forces the crystal source for as long as it is held.

A change of source uses a break-before-make handshake. The new request is synchronized into each source domain. The path that is currently driving the output is switched off first, on a falling edge of its own source, and only while its halved clock is low. The other path is switched on afterwards in the same way. While no path is enabled, the output stays low, so it never shows a runt pulse or a glitch. A status output goes high only once the VCO path has actually been enabled.

Top module: `base_clk_sel`

## Requirements
- R1: While the effective selection is the crystal (sel_vco = 0, or stop_req = 1), base_clk runs at half the clk_ref frequency. Its rising edges are two clk_ref periods apart.
- R2: While sel_vco = 1 and stop_req = 0, and once the switch has completed, base_clk runs at half the clk_vco frequency. Its rising edges are two clk_vco periods apart.
- R3: Outside reset, no high phase or low phase of base_clk is shorter than half the period of the faster of the two halved source clocks. This holds across every switch of source.
- R4: The two source paths are never enabled at the same time. While neither path is enabled, base_clk is held low. At the moment vco_active changes level, base_clk is low.
- R5: After a request moves the selection to the VCO, vco_active rises within 4 clk_ref periods plus 4 clk_vco periods. After a request moves it back to the crystal, vco_active falls within 4 clk_vco periods.
- R6: vco_active = 1 only while the VCO path is enabled. It is still 0 just after the request is made, and it is never 1 while the crystal path is enabled.
- R7: While stop_req = 1, the crystal source is used and sel_vco has no effect (vco_active stays 0). When stop_req is released with sel_vco = 1, the VCO source is selected again.
- R8: rst_n is asynchronous and active low. While it is low, base_clk = 0 and vco_active = 0. After it is released, the crystal source drives base_clk if sel_vco = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Crystal-derived source clock |
| clk_vco | input | 1 | VCO-derived source clock, asynchronous to clk_ref |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_vco | input | 1 | Source request: 1 selects the VCO clock, 0 selects the crystal clock |
| stop_req | input | 1 | Forces the crystal source while high |
| base_clk | output | 1 | Selected source divided by two |
| vco_active | output | 1 | High while the VCO path drives base_clk |

## Verification
A path enable that flips while its halved clock is high shows up on base_clk as a short phase within one source half-period. The phase monitor measures every high and low phase and compares it against the minimum. If both enables were stuck high, or if an enable never cleared, base_clk would carry a mix of the two periods. A period check taken a few tens of nanoseconds after each switch detects that. A synchronizer that is too slow or stuck shows up as vco_active missing its latency bound. A broken stop override shows up as vco_active rising during the hold window.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam int NUM_LEGS = 2;
  localparam int LEG_REF  = 0;
  localparam int LEG_VCO  = 1;

  // stop overrides the select input
  function automatic logic effective_select(input logic sel, input logic stop);
    return sel & ~stop;
  endfunction

  // a leg may ask to be enabled only while the peer leg is fully idle
  function automatic logic leg_request(input logic pick_me, input logic peer_busy);
    return pick_me & ~peer_busy;
  endfunction

  // an enable may change only while the halved clock sits low
  function automatic logic gate_open(input logic div_level);
    return ~div_level;
  endfunction

  function automatic logic merge_legs(input logic [NUM_LEGS-1:0] div_lvl,
                                      input logic [NUM_LEGS-1:0] en_lvl);
    return |(div_lvl & en_lvl);
  endfunction
endpackage

// File: rtl/bcs_sync.sv
`timescale 1ns/1ps
module bcs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic any_q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q     = chain[STAGES-1];
  assign any_q = |chain;
endmodule

// File: rtl/bcs_leg.sv
`timescale 1ns/1ps
module bcs_leg
  import bcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit EN_AT_RESET = 1'b0
) (
  input  logic clk_src,
  input  logic rst_n,
  input  logic want,
  output logic div_q,
  output logic en_q,
  output logic busy
);
  logic want_seen;
  logic want_pending;

  // free-running divide-by-two toggle
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) div_q <= 1'b0;
    else        div_q <= ~div_q;
  end

  bcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(EN_AT_RESET)) u_sync (
    .clk   (clk_src),
    .rst_n (rst_n),
    .d     (want),
    .q     (want_seen),
    .any_q (want_pending)
  );

  // enable moves on the falling source edge while the halved clock is low
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n)                en_q <= EN_AT_RESET;
    else if (gate_open(div_q)) en_q <= want_seen;
  end

  assign busy = en_q | want_pending;
endmodule

// File: rtl/base_clk_sel.sv
`timescale 1ns/1ps
module base_clk_sel
  import bcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic clk_vco,
  input  logic rst_n,
  input  logic sel_vco,
  input  logic stop_req,
  output logic base_clk,
  output logic vco_active
);
  logic                sel_eff;
  logic [NUM_LEGS-1:0] src_clk;
  logic [NUM_LEGS-1:0] leg_want;
  logic [NUM_LEGS-1:0] leg_div;
  logic [NUM_LEGS-1:0] leg_en;
  logic [NUM_LEGS-1:0] leg_busy;

  // named internal events for the checker
  logic ref_en, vco_en, ref_div, vco_div;

  assign sel_eff          = effective_select(sel_vco, stop_req);
  assign src_clk[LEG_REF] = clk_ref;
  assign src_clk[LEG_VCO] = clk_vco;
  assign leg_want[LEG_REF] = leg_request(~sel_eff, leg_busy[LEG_VCO]);
  assign leg_want[LEG_VCO] = leg_request(sel_eff,  leg_busy[LEG_REF]);

  generate
    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
      bcs_leg #(
        .SYNC_STAGES (SYNC_STAGES),
        .EN_AT_RESET (i == LEG_REF)
      ) u_leg (
        .clk_src (src_clk[i]),
        .rst_n   (rst_n),
        .want    (leg_want[i]),
        .div_q   (leg_div[i]),
        .en_q    (leg_en[i]),
        .busy    (leg_busy[i])
      );
    end
  endgenerate

  assign ref_en  = leg_en[LEG_REF];
  assign vco_en  = leg_en[LEG_VCO];
  assign ref_div = leg_div[LEG_REF];
  assign vco_div = leg_div[LEG_VCO];

  assign base_clk   = merge_legs(leg_div, leg_en);
  assign vco_active = vco_en;
endmodule

// File: rtl/bcs_checker.sv
`timescale 1ns/1ps
module bcs_checker (
  input logic clk_ref,
  input logic clk_vco,
  input logic rst_n,
  input logic base_clk,
  input logic vco_active,
  input logic ref_en,
  input logic vco_en,
  input logic ref_div,
  input logic vco_div
);
  // R4
  exclusive_ref_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(ref_en && vco_en));

  // R4
  exclusive_vco_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !(ref_en && vco_en));

  // R3
  ref_gate_chk: assert property (@(negedge clk_ref) disable iff (!rst_n)
    !$stable(ref_en) |-> !$past(ref_div));

  // R3
  vco_gate_chk: assert property (@(negedge clk_vco) disable iff (!rst_n)
    !$stable(vco_en) |-> !$past(vco_div));

  // R4
  frozen_low_chk: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (!ref_en && !vco_en) |-> !base_clk);

  // R6
  status_excl_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    vco_active |-> !ref_en);
endmodule

bind base_clk_sel bcs_checker u_chk (
  .clk_ref    (clk_ref),
  .clk_vco    (clk_vco),
  .rst_n      (rst_n),
  .base_clk   (base_clk),
  .vco_active (vco_active),
  .ref_en     (ref_en),
  .vco_en     (vco_en),
  .ref_div    (ref_div),
  .vco_div    (vco_div)
);

// File: tb/base_clk_sel_test.sv
`timescale 1ns/1ps
module base_clk_sel_test;
  localparam real REF_HALF = 2.5;   // 200 MHz
  localparam real VCO_HALF = 1.7;
  localparam real REF_DIV_PER = 4.0 * REF_HALF;
  localparam real VCO_DIV_PER = 4.0 * VCO_HALF;
  localparam real MIN_PHASE = VCO_HALF * 2.0;  // half of faster divided period
  localparam real TO_VCO_LIMIT = 4.0 * 2.0 * REF_HALF + 4.0 * 2.0 * VCO_HALF;
  localparam real TO_REF_LIMIT = 4.0 * 2.0 * VCO_HALF;

  logic clk_ref = 1'b0;
  logic clk_vco = 1'b0;
  logic rst_n = 1'b0;
  logic sel_vco = 1'b0;
  logic stop_req = 1'b0;
  logic base_clk, vco_active;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  base_clk_sel uut (
    .clk_ref(clk_ref), .clk_vco(clk_vco), .rst_n(rst_n),
    .sel_vco(sel_vco), .stop_req(stop_req),
    .base_clk(base_clk), .vco_active(vco_active)
  );

  initial forever #(REF_HALF) clk_ref = ~clk_ref;
  initial begin
    #0.9;
    forever #(VCO_HALF) clk_vco = ~clk_vco;
  end

  // phase monitor
  bit  mon_en = 1'b0;
  bit  armed = 1'b0;
  real last_edge = 0.0;
  real min_seen = 1.0e9;
  int  runts = 0;
  always @(base_clk) begin
    if (mon_en) begin
      if (armed) begin
        if ($realtime - last_edge < min_seen) min_seen = $realtime - last_edge;
        if ($realtime - last_edge < MIN_PHASE - 0.01) runts++;
      end
      armed = 1'b1;
      last_edge = $realtime;
    end
  end

  task automatic check(input bit ok, input string tag, input real act, input real exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0.3f expected %0.3f", tag, act, exp);
    end
  endtask

  task automatic check_period(input real exp, input string tag);
    real t0, p;
    @(posedge base_clk);
    t0 = $realtime;
    @(posedge base_clk);
    p = $realtime - t0;
    check((p > exp - 0.02) && (p < exp + 0.02), tag, p, exp);
  endtask

  task automatic wait_status(input logic target, input real limit, input string tag);
    real t0, took;
    t0 = $realtime;
    took = -1.0;
    for (int i = 0; i <= int'(limit * 10.0) + 1; i++) begin
      if (vco_active === target) begin
        took = $realtime - t0;
        break;
      end
      #0.1;
    end
    check((took >= 0.0) && (took <= limit + 0.1), {tag, " switch latency"}, took, limit);
    // R4: output low at the moment the status flips
    check(base_clk === 1'b0, "R4 base_clk low at status change", real'(base_clk), 0.0);
  endtask

  task automatic t_reset;
    #3.3;
    // R8
    check(base_clk === 1'b0, "R8 base_clk in reset", real'(base_clk), 0.0);
    check(vco_active === 1'b0, "R8 vco_active in reset", real'(vco_active), 0.0);
    #10.0;
    check(base_clk === 1'b0, "R8 base_clk held in reset", real'(base_clk), 0.0);
    #7.0;
    rst_n = 1'b1;
    #12.0;
    mon_en = 1'b1;
    check_period(REF_DIV_PER, "R8 R1 crystal after reset");
  endtask

  task automatic t_to_vco(input real lead);
    #(lead);
    sel_vco = 1'b1;
    #0.2;
    // R6
    check(vco_active === 1'b0, "R6 status not set on request", real'(vco_active), 0.0);
    wait_status(1'b1, TO_VCO_LIMIT - 0.2, "R5 R6 to vco");
    check_period(VCO_DIV_PER, "R2 vco divided period");
  endtask

  task automatic t_to_ref(input real lead);
    #(lead);
    sel_vco = 1'b0;
    wait_status(1'b0, TO_REF_LIMIT, "R5 to crystal");
    #30.0;
    check_period(REF_DIV_PER, "R1 crystal divided period");
  endtask

  task automatic t_stop;
    int ones;
    t_to_vco(0.37);
    #1.13;
    stop_req = 1'b1;
    wait_status(1'b0, TO_REF_LIMIT, "R7 stop forces crystal");
    #30.0;
    check_period(REF_DIV_PER, "R7 R1 crystal under stop");
    ones = 0;
    for (int i = 0; i < 1000; i++) begin
      if (i == 300) sel_vco = 1'b0;
      if (i == 500) sel_vco = 1'b1;
      if (vco_active !== 1'b0) ones++;
      #0.1;
    end
    check(ones == 0, "R7 select ignored during stop", real'(ones), 0.0);
    check_period(REF_DIV_PER, "R7 still crystal during stop");
    #0.41;
    stop_req = 1'b0;
    wait_status(1'b1, TO_VCO_LIMIT, "R7 R5 stop released");
    check_period(VCO_DIV_PER, "R7 R2 vco after stop");
  endtask

  task automatic t_reset_mid;
    #2.07;
    mon_en = 1'b0;
    armed = 1'b0;
    rst_n = 1'b0;
    sel_vco = 1'b0;
    #0.3;
    check(base_clk === 1'b0, "R8 async reset clears output", real'(base_clk), 0.0);
    check(vco_active === 1'b0, "R8 async reset clears status", real'(vco_active), 0.0);
    #19.93;
    rst_n = 1'b1;
    #12.0;
    mon_en = 1'b1;
    check_period(REF_DIV_PER, "R8 R1 crystal after mid reset");
  endtask

  initial begin
    t_reset();
    t_to_vco(0.61);
    t_to_ref(1.23);
    t_to_vco(3.05);
    t_to_ref(0.77);
    t_stop();
    t_reset_mid();
    t_to_vco(2.44);
    t_to_ref(4.11);
    // R3
    check(runts == 0, "R3 runt phases", real'(runts), 0.0);
    check(min_seen >= MIN_PHASE - 0.01, "R3 shortest phase", min_seen, MIN_PHASE);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000.0;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule